// File: doc/BRIEF.md
# Flash Read Port Arbiter

This block shares one synchronous flash read port between two requesters: an instruction-fetch port and a data port. The data port carries both CPU data loads and DMA transfers, and a side input tells the arbiter which of the two is driving a given request. In any cycle at most one port is granted. The winning address goes to the flash array, and the read data comes back one cycle later with a valid pulse on the granted port only.

Data-port requests normally win over instruction fetches. After every granted DMA transfer, however, the arbiter inserts one cycle in which the data port cannot be granted. An instruction fetch that is waiting is served in that cycle, so a long DMA burst cannot starve instruction fetches. CPU data grants do not create this gap.

The block also holds a 32-bit control register. One bit of that register enables half-cycle flash access, and the bit is driven out to the flash timing logic. The flash array is modelled as a one-cycle synchronous read memory. Its contents are computed from the address.

Top module: `flash_port_arb`

## Requirements
- R1: After reset, no read-valid pulse appears, `cfg_rdata_o` reads 0x0000_0000 at offset 0, `half_cycle_o` is 0, and neither grant is asserted while no request is present.
- R2: When both ports request and the data port is not in its post-DMA gap, the data port is granted and the instruction port is not, in the same cycle.
- R3: In the cycle after a data-port grant with `dp_dma_i` = 1, the data port is not granted, even if it is still requesting.
- R4: An instruction request present in the cycle after a DMA grant is granted in that cycle. A data grant with `dp_dma_i` = 0 creates no gap, so the data port can be granted again in the very next cycle.
- R5: In any cycle, at most one of `if_gnt_o` and `dp_gnt_o` is high. A grant is given only to a port whose request is high.
- R6: One cycle after a grant, the granted port's `*_rvalid_o` is high and the other port's is low. The read data is the flash word at the granted address. The word at address a (ADDR_W = 16) is {~a, a}, with ~a in bits 31:16 and a in bits 15:0.
- R7: A write to offset 0x0 stores only bit 3. Bit 3 drives `half_cycle_o` (1 enables, 0 disables) and reads back in bit 3. Bits 31:4 and 2:0 always read zero, even after ones are written to them.
- R8: A write to any nonzero offset is ignored, leaving `half_cycle_o` unchanged. A read of any nonzero offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| if_req_i | input | 1 | Instruction-fetch request |
| if_addr_i | input | ADDR_W | Instruction-fetch word address, held until granted |
| if_gnt_o | output | 1 | Instruction-fetch grant, same cycle as the request |
| if_rvalid_o | output | 1 | Instruction read data valid |
| if_rdata_o | output | 2*ADDR_W | Instruction read data |
| dp_req_i | input | 1 | Data-port request |
| dp_dma_i | input | 1 | 1: the data request comes from DMA; 0: it comes from the CPU |
| dp_addr_i | input | ADDR_W | Data-port word address, held until granted |
| dp_gnt_o | output | 1 | Data-port grant |
| dp_rvalid_o | output | 1 | Data-port read data valid |
| dp_rdata_o | output | 2*ADDR_W | Data-port read data |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_addr_i | input | CFG_AW | Control register byte offset |
| cfg_wdata_i | input | 32 | Control register write data |
| cfg_rdata_o | output | 32 | Control register read data for `cfg_addr_i` |
| half_cycle_o | output | 1 | Half-cycle access enable |

## Verification
The bench builds the block with ADDR_W = 16 and CFG_AW = 4. With these values the flash word is {~a, a}, so the data returned on each port proves which address won arbitration. The 4-bit offset lets the bench reach nonzero register offsets. A vector table walks back-to-back DMA bursts, CPU data streams and mixed contention. Together these reach the gap cycle both with and without a pending fetch, and the case where the gap cycle falls when no data request is present.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;
  localparam int unsigned CFG_W       = 32;
  localparam int unsigned HALF_BIT    = 3;
  localparam int unsigned CTRL_OFFSET = 0;

  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_IF   = 2'b01,
    OWN_DP   = 2'b10
  } owner_e;
endpackage

// File: rtl/flash_arb_core.sv
module flash_arb_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic if_req_i,
  input  logic dp_req_i,
  input  logic dp_dma_i,
  output logic if_gnt_o,
  output logic dp_gnt_o
);
  logic gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= 1'b0;
    else         gap_q <= dp_gnt_o && dp_dma_i;
  end

  always_comb begin
    dp_gnt_o = dp_req_i && !gap_q;
    if_gnt_o = if_req_i && !dp_gnt_o;
  end

  // R3
  dma_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_gnt_o && dp_dma_i) |=> !dp_gnt_o);

  // R4
  fetch_in_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_gnt_o && dp_dma_i) |=> (if_req_i -> if_gnt_o));

  // R4
  cpu_no_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_gnt_o && !dp_dma_i) |=> (dp_req_i -> dp_gnt_o));
endmodule

// File: rtl/flash_rd_array.sv
module flash_rd_array #(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned DATA_W = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  // Contents derived from the address: upper half inverted, lower half plain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (en_i) rdata_o <= {~addr_i, addr_i};
  end
endmodule

// File: rtl/flash_ctrl_reg.sv
module flash_ctrl_reg
  import flash_arb_pkg::*;
#(
  parameter int unsigned CFG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  output logic [CFG_W-1:0]  rdata_o,
  output logic              half_cycle_o
);
  logic half_q;
  logic hit;
  logic unused_wdata;

  assign hit          = (addr_i == CFG_AW'(CTRL_OFFSET));
  assign unused_wdata = ^{wdata_i[CFG_W-1:HALF_BIT+1], wdata_i[HALF_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         half_q <= 1'b0;
    else if (we_i && hit) half_q <= wdata_i[HALF_BIT];
  end

  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o[HALF_BIT] = half_q;
  end

  assign half_cycle_o = half_q;

  // R8
  off_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != '0) |=> $stable(half_cycle_o));

  // R7
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~(CFG_W'(1) << HALF_BIT)) == '0);
endmodule

// File: rtl/flash_port_arb.sv
module flash_port_arb
  import flash_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CFG_AW = 4,
  localparam int unsigned DATA_W = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              if_req_i,
  input  logic [ADDR_W-1:0] if_addr_i,
  output logic              if_gnt_o,
  output logic              if_rvalid_o,
  output logic [DATA_W-1:0] if_rdata_o,
  input  logic              dp_req_i,
  input  logic              dp_dma_i,
  input  logic [ADDR_W-1:0] dp_addr_i,
  output logic              dp_gnt_o,
  output logic              dp_rvalid_o,
  output logic [DATA_W-1:0] dp_rdata_o,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              half_cycle_o
);
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  owner_e            owner_q;

  flash_arb_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .if_req_i (if_req_i),
    .dp_req_i (dp_req_i),
    .dp_dma_i (dp_dma_i),
    .if_gnt_o (if_gnt_o),
    .dp_gnt_o (dp_gnt_o)
  );

  assign rd_en   = if_gnt_o || dp_gnt_o;
  assign rd_addr = dp_gnt_o ? dp_addr_i : if_addr_i;

  flash_rd_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rd_en),
    .addr_i  (rd_addr),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       owner_q <= OWN_NONE;
    else if (dp_gnt_o) owner_q <= OWN_DP;
    else if (if_gnt_o) owner_q <= OWN_IF;
    else               owner_q <= OWN_NONE;
  end

  assign if_rvalid_o = (owner_q == OWN_IF);
  assign dp_rvalid_o = (owner_q == OWN_DP);
  assign if_rdata_o  = rd_data;
  assign dp_rdata_o  = rd_data;

  flash_ctrl_reg #(.CFG_AW(CFG_AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .addr_i       (cfg_addr_i),
    .wdata_i      (cfg_wdata_i),
    .rdata_o      (cfg_rdata_o),
    .half_cycle_o (half_cycle_o)
  );

  // R5
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({if_gnt_o, dp_gnt_o}) && (if_gnt_o -> if_req_i) && (dp_gnt_o -> dp_req_i));

  // R2
  dp_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_req_i && dp_req_i && !if_gnt_o) |-> dp_gnt_o);

  // R6
  dp_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_gnt_o |=> (dp_rvalid_o && !if_rvalid_o));

  // R6
  if_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_gnt_o |=> (if_rvalid_o && !dp_rvalid_o && if_rdata_o == {~$past(if_addr_i), $past(if_addr_i)}));

  // R1
  rvalid_no_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(if_gnt_o || dp_gnt_o) |=> !(if_rvalid_o || dp_rvalid_o));
endmodule

// File: tb/flash_port_arb_tb.sv
module flash_port_arb_tb;
  localparam int unsigned AW = 16;
  localparam int unsigned NV = 12;
  // [4] if_req [3] dp_req [2] dp_dma [1] expected if_gnt [0] expected dp_gnt
  localparam logic [4:0] VEC [0:NV-1] = '{
    5'b10010, 5'b11001, 5'b11101, 5'b11110, 5'b11101, 5'b01100,
    5'b01101, 5'b10010, 5'b00000, 5'b11001, 5'b11001, 5'b10010
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          if_req = 1'b0, dp_req = 1'b0, dp_dma = 1'b0;
  logic [AW-1:0] if_addr = '0, dp_addr = '0;
  logic          if_gnt, if_rvalid, dp_gnt, dp_rvalid;
  logic [2*AW-1:0] if_rdata, dp_rdata;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0, cfg_rdata;
  logic          half_cycle;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  flash_port_arb #(.ADDR_W(AW), .CFG_AW(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .if_req_i(if_req), .if_addr_i(if_addr), .if_gnt_o(if_gnt),
    .if_rvalid_o(if_rvalid), .if_rdata_o(if_rdata),
    .dp_req_i(dp_req), .dp_dma_i(dp_dma), .dp_addr_i(dp_addr),
    .dp_gnt_o(dp_gnt), .dp_rvalid_o(dp_rvalid), .dp_rdata_o(dp_rdata),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .half_cycle_o(half_cycle)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*AW-1:0] word_at(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  // Drive just after the edge, sample in mid-cycle
  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic prev_if, prev_dp;
    logic [AW-1:0] prev_addr;
    prev_if = 1'b0; prev_dp = 1'b0; prev_addr = '0;

    repeat (3) next_cycle();
    rst_n = 1'b1;
    next_cycle();
    #2;
    // R1 reset state
    chk(!if_gnt && !dp_gnt, "R1 no grant idle", {if_gnt, dp_gnt}, 0);
    chk(!if_rvalid && !dp_rvalid, "R1 no rvalid", {if_rvalid, dp_rvalid}, 0);
    chk(cfg_rdata == 32'h0, "R1 cfg reset", cfg_rdata, 0);
    chk(half_cycle == 1'b0, "R1 half_cycle reset", half_cycle, 0);

    // Vector walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      next_cycle();
      if_req  = VEC[i][4];
      dp_req  = VEC[i][3];
      dp_dma  = VEC[i][2];
      if_addr = AW'(16'h1000 + i);
      dp_addr = AW'(16'h8A00 + i);
      #2;
      chk(if_gnt == VEC[i][1] && dp_gnt == VEC[i][0], $sformatf("R2/R3/R4 grant vec %0d", i),
          {if_gnt, dp_gnt}, VEC[i][1:0]);
      chk(!(if_gnt && dp_gnt), "R5 single grant", {if_gnt, dp_gnt}, 0);
      chk(if_rvalid == prev_if && dp_rvalid == prev_dp, $sformatf("R6 rvalid vec %0d", i),
          {if_rvalid, dp_rvalid}, {prev_if, prev_dp});
      if (prev_if || prev_dp)
        chk(if_rdata == word_at(prev_addr), $sformatf("R6 rdata vec %0d", i), if_rdata, word_at(prev_addr));
      prev_if   = VEC[i][1];
      prev_dp   = VEC[i][0];
      prev_addr = VEC[i][0] ? dp_addr : if_addr;
    end
    next_cycle();
    if_req = 1'b0; dp_req = 1'b0; dp_dma = 1'b0;
    #2;
    chk(if_rvalid == prev_if && dp_rvalid == prev_dp, "R6 last rvalid", {if_rvalid, dp_rvalid}, {prev_if, prev_dp});
    chk(dp_rdata == word_at(prev_addr), "R6 last rdata", dp_rdata, word_at(prev_addr));
    next_cycle();
    #2;
    chk(!if_rvalid && !dp_rvalid, "R6 no rvalid after idle", {if_rvalid, dp_rvalid}, 0);

    // R3 gap with no fetch pending: data port stays ungranted for one cycle
    next_cycle();
    dp_req = 1'b1; dp_dma = 1'b1; dp_addr = 16'h00FF;
    #2;
    chk(dp_gnt, "R3 dma granted", dp_gnt, 1);
    next_cycle();
    #2;
    chk(!dp_gnt && !if_gnt, "R3 gap cycle empty", {if_gnt, dp_gnt}, 0);
    chk(dp_rvalid && dp_rdata == word_at(16'h00FF), "R6 dma data", dp_rdata, word_at(16'h00FF));
    next_cycle();
    dp_req = 1'b0; dp_dma = 1'b0;

    // R7 control register
    next_cycle();
    cfg_we = 1'b1; cfg_addr = 4'h0; cfg_wdata = 32'hFFFF_FFFF;
    next_cycle();
    cfg_we = 1'b0;
    #2;
    chk(cfg_rdata == 32'h0000_0008, "R7 reserved bits zero", cfg_rdata, 32'h8);
    chk(half_cycle == 1'b1, "R7 half_cycle set", half_cycle, 1);

    // R8 other offsets ignored
    next_cycle();
    cfg_we = 1'b1; cfg_addr = 4'h4; cfg_wdata = 32'h0;
    next_cycle();
    cfg_we = 1'b0;
    #2;
    chk(half_cycle == 1'b1, "R8 write at 0x4 ignored", half_cycle, 1);
    chk(cfg_rdata == 32'h0, "R8 read at 0x4 zero", cfg_rdata, 0);
    cfg_addr = 4'h0;
    #1;
    chk(cfg_rdata == 32'h8, "R8 offset 0 kept", cfg_rdata, 32'h8);

    // R7 clear
    next_cycle();
    cfg_we = 1'b1; cfg_addr = 4'h0; cfg_wdata = 32'hFFFF_FFF7;
    next_cycle();
    cfg_we = 1'b0;
    #2;
    chk(half_cycle == 1'b0 && cfg_rdata == 32'h0, "R7 half_cycle cleared", cfg_rdata, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule